// File: doc/BRIEF.md
# Loopback Pattern Generator and Checker

This block drives a deterministic test word, one bit per pad lane, towards the output pads and checks the word that comes back through the receive capture path. Each lane's bit sequence is set by a shared stress mode: a single lane switching at a time, all lanes switching together, a per-lane pseudo-random sequence that exercises intersymbol interference, or toggling aggressors around one quiet victim lane. A lane mask takes individual lanes out of both driving and checking.

The returned word is compared with an internally delayed copy of the expected word. The delay is programmable from one to four cycles so that it matches the loop through pad, strobe and capture latches. A second compare mode checks the captured word against the word launched one cycle after the aligned one, which is what a capture strobe pushed into the next data cycle sees. Mismatches set sticky per-lane flags and an aggregate flag, and the lowest lane of the first failing cycle is recorded, until software clears them.

The outbound and inbound words flow on every data clock while the loop runs and take no back-pressure: the data clock and launch stay fixed during a check, so neither side has a valid or ready handshake. `lb_en` acts as the sole qualifier of the outbound stream; the inbound word is sampled every cycle and checked only where a launched word is expected back.

Top module: `lpbk_pattern_check`

## Requirements
- R1: After reset `tx_data`, `lane_fail`, `any_fail` and `first_lane` are all zero.
- R2: While `lb_en` is low `tx_data` is zero one cycle later; on each rise of `lb_en` the sequence restarts at word 0, which appears on `tx_data` the cycle after `lb_en` is first sampled high, then one word per cycle.
- R3: With `pat_mode` = 2'b00 word k has only lane (k mod LANES) high.
- R4: With `pat_mode` = 2'b01 every lane is high in even words k and low in odd words.
- R5: With `pat_mode` = 2'b10 lane i carries bit 6 of its own 7-bit shift register, seeded with i+1 at word 0 and advanced per word as s' = {s[5:0], s[6]^s[5]}.
- R6: With `pat_mode` = 2'b11 all lanes follow the R4 toggle except lane `victim_sel`, which stays low.
- R7: A lane whose `lane_mask` bit is 0 drives 0 and a mismatch on it never sets a fail flag.
- R8: With `cmp_next` low, `rx_data` equal to `tx_data` delayed by `loop_lat`+1 cycles gives no fail; in toggle mode a delay one cycle shorter fails.
- R9: With `cmp_next` high, `rx_data` equal to `tx_data` delayed by `loop_lat` cycles gives no fail; in toggle mode a delay of `loop_lat`+1 fails.
- R10: A mismatch on a checked lane sets that bit of `lane_fail` and `any_fail` in the cycle after the capture edge; they stay set until `clr_fail`.
- R11: `first_lane` takes the lowest mismatching lane of the first failing cycle after a clear and holds it while fails are held.
- R12: A mismatch in the same cycle as `clr_fail` is kept: the flags then show only the new lanes and `first_lane` their lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Active-low reset |
| lb_en | input | 1 | Runs the loop; low holds the generator at word 0 |
| pat_mode | input | 2 | 00 walking one, 01 all toggle, 10 per-lane pseudo-random, 11 victim/aggressor |
| cmp_next | input | 1 | 1 compares against the following word |
| loop_lat | input | 2 | Expected loop latency minus one |
| victim_sel | input | 3 | Quiet lane in victim/aggressor mode |
| lane_mask | input | 8 | 1 enables a lane for driving and checking |
| clr_fail | input | 1 | Clears sticky results |
| rx_data | input | 8 | Captured inbound word |
| tx_data | output | 8 | Outbound pattern word |
| lane_fail | output | 8 | Sticky per-lane fail flags |
| any_fail | output | 1 | Sticky aggregate fail |
| first_lane | output | 3 | Lowest lane of first failing cycle |

## Verification
The clear of the sticky results and the capture of a fresh mismatch can land on the same clock edge. The bench provokes this by presenting a single-cycle bit flip on the inbound word on the very cycle it raises the clear, while results from earlier failures are still held. It judges the outcome by requiring the flags to show exactly the newly flipped lanes and the recorded lane to move to their lowest, so neither stale lanes nor a lost failure pass.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  typedef enum logic [1:0] {
    PM_WALK   = 2'b00,
    PM_TOGGLE = 2'b01,
    PM_PRBS   = 2'b10,
    PM_XTALK  = 2'b11
  } pmode_e;

  localparam int SR_W = 7;

  function automatic logic [SR_W-1:0] sr_step(input logic [SR_W-1:0] s);
    return {s[SR_W-2:0], s[SR_W-1] ^ s[SR_W-2]};
  endfunction
endpackage

// File: rtl/lbk_patgen.sv
module lbk_patgen
  import lbk_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IDXW  = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  pmode_e           mode,
  input  logic [IDXW-1:0]  victim,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] tx_q,
  output logic             tx_v,
  output logic [LANES-1:0] lead_m
);
  logic [IDXW-1:0] ptr_q;
  logic            ph_q;
  logic [SR_W-1:0] sr_q [LANES];
  logic [LANES-1:0] word;

  // each lane owns its shift register
  for (genvar g = 0; g < LANES; g++) begin : g_sr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sr_q[g] <= SR_W'(g + 1);
      else if (!run) sr_q[g] <= SR_W'(g + 1);
      else          sr_q[g] <= sr_step(sr_q[g]);
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      unique case (mode)
        PM_WALK:   word[i] = (ptr_q == IDXW'(i));
        PM_TOGGLE: word[i] = ~ph_q;
        PM_PRBS:   word[i] = sr_q[i][SR_W-1];
        default:   word[i] = ~ph_q & (victim != IDXW'(i));
      endcase
    end
  end

  assign lead_m = word & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ph_q  <= 1'b0;
      tx_q  <= '0;
      tx_v  <= 1'b0;
    end else if (!run) begin
      ptr_q <= '0;
      ph_q  <= 1'b0;
      tx_q  <= '0;
      tx_v  <= 1'b0;
    end else begin
      ptr_q <= (ptr_q == IDXW'(LANES - 1)) ? '0 : ptr_q + 1'b1;
      ph_q  <= ~ph_q;
      tx_q  <= lead_m;
      tx_v  <= 1'b1;
    end
  end
endmodule

// File: rtl/lbk_align.sv
module lbk_align #(
  parameter int LANES   = 8,
  parameter int LAT_MAX = 4,
  localparam int LATW   = $clog2(LAT_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  input  logic             vin,
  input  logic [LATW-1:0]  sel,
  output logic [LANES-1:0] dout,
  output logic             vout
);
  logic [LANES-1:0] st_d [LAT_MAX];
  logic [LAT_MAX-1:0] st_v;

  for (genvar s = 0; s < LAT_MAX; s++) begin : g_st
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_d[s] <= '0;
        st_v[s] <= 1'b0;
      end else if (s == 0) begin
        st_d[s] <= din;
        st_v[s] <= vin;
      end else begin
        st_d[s] <= st_d[(s == 0) ? 0 : s - 1];
        st_v[s] <= st_v[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign dout = st_d[sel];
  assign vout = st_v[sel];
endmodule

// File: rtl/lbk_judge.sv
module lbk_judge #(
  parameter int LANES = 8,
  parameter int IDXW  = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mism,
  input  logic             clr,
  output logic [LANES-1:0] lane_fail,
  output logic             any_fail,
  output logic [IDXW-1:0]  first_lane
);
  logic [IDXW-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (mism[i]) low_idx = IDXW'(i);
  end

  assign any_fail = |lane_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_fail  <= '0;
      first_lane <= '0;
    end else begin
      lane_fail <= (clr ? '0 : lane_fail) | mism;
      if ((clr || !any_fail) && (|mism)) first_lane <= low_idx;
      else if (clr)                      first_lane <= '0;
    end
  end
endmodule

// File: rtl/lpbk_pattern_check.sv
module lpbk_pattern_check
  import lbk_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int LAT_MAX = 4,
  localparam int IDXW   = $clog2(LANES),
  localparam int LATW   = $clog2(LAT_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lb_en,
  input  logic [1:0]       pat_mode,
  input  logic             cmp_next,
  input  logic [LATW-1:0]  loop_lat,
  input  logic [IDXW-1:0]  victim_sel,
  input  logic [LANES-1:0] lane_mask,
  input  logic             clr_fail,
  input  logic [LANES-1:0] rx_data,
  output logic [LANES-1:0] tx_data,
  output logic [LANES-1:0] lane_fail,
  output logic             any_fail,
  output logic [IDXW-1:0]  first_lane
);
  logic [LANES-1:0] tx_q, lead_m, exp_w, ref_w, mism;
  logic             tx_v, exp_v, ref_v;

  lbk_patgen #(.LANES(LANES), .IDXW(IDXW)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(lb_en), .mode(pmode_e'(pat_mode)),
    .victim(victim_sel), .mask(lane_mask),
    .tx_q(tx_q), .tx_v(tx_v), .lead_m(lead_m)
  );

  // next-word compare only counts when that word is really launched
  assign ref_w = cmp_next ? lead_m : tx_q;
  assign ref_v = tx_v & (lb_en | ~cmp_next);

  lbk_align #(.LANES(LANES), .LAT_MAX(LAT_MAX)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(ref_w), .vin(ref_v), .sel(loop_lat),
    .dout(exp_w), .vout(exp_v)
  );

  assign mism = (rx_data ^ exp_w) & lane_mask & {LANES{exp_v}};

  lbk_judge #(.LANES(LANES), .IDXW(IDXW)) u_jdg (
    .clk(clk), .rst_n(rst_n), .mism(mism), .clr(clr_fail),
    .lane_fail(lane_fail), .any_fail(any_fail), .first_lane(first_lane)
  );

  assign tx_data = tx_q;
endmodule

// File: rtl/lpbk_pattern_check_chk.sv
module lpbk_pattern_check_chk #(
  parameter int LANES = 8,
  localparam int IDXW = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lb_en,
  input logic [1:0]       pat_mode,
  input logic [IDXW-1:0]  victim_sel,
  input logic [LANES-1:0] lane_mask,
  input logic             clr_fail,
  input logic [LANES-1:0] tx_data,
  input logic [LANES-1:0] lane_fail,
  input logic             any_fail,
  input logic [IDXW-1:0]  first_lane
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_en |=> tx_data == '0);

  // R3
  walk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_mode == 2'b00 |=> $onehot0(tx_data));

  // R4
  sso_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && pat_mode == 2'b01 && $past(lb_en) && $past(pat_mode) == 2'b01 &&
     $stable(lane_mask)) |=> tx_data == (~$past(tx_data) & $past(lane_mask)));

  // R6
  victim_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_mode == 2'b11 |=> tx_data[$past(victim_sel)] == 1'b0);

  // R7
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_en |=> (tx_data & ~$past(lane_mask)) == '0);

  // R10
  sticky_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fail && !clr_fail) |=> any_fail);

  // R10
  sticky_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fail |=> ($past(lane_fail) & ~lane_fail) == '0);

  // R11
  first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fail && !clr_fail) |=> $stable(first_lane));

  // R11
  first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_fail) |-> lane_fail[first_lane]);
endmodule

bind lpbk_pattern_check lpbk_pattern_check_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lb_en(lb_en), .pat_mode(pat_mode),
  .victim_sel(victim_sel), .lane_mask(lane_mask), .clr_fail(clr_fail),
  .tx_data(tx_data), .lane_fail(lane_fail), .any_fail(any_fail),
  .first_lane(first_lane)
);

// File: tb/sim_lpbk_pattern_check.sv
module sim_lpbk_pattern_check;
  localparam int LANES = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lb_en = 1'b0;
  logic [1:0] pat_mode = 2'b00;
  logic       cmp_next = 1'b0;
  logic [1:0] loop_lat = 2'd0;
  logic [2:0] victim_sel = 3'd0;
  logic [7:0] lane_mask = 8'hFF;
  logic       clr_fail = 1'b0;
  logic [7:0] rx_data, tx_data, lane_fail, inj = 8'h00;
  logic       any_fail;
  logic [2:0] first_lane;
  int         bd = 1;
  int         n_chk = 0, n_err = 0;
  logic [7:0] pad [1:4];
  bit         done = 0;

  always #2 clk = ~clk;

  lpbk_pattern_check u0 (
    .clk(clk), .rst_n(rst_n), .lb_en(lb_en), .pat_mode(pat_mode),
    .cmp_next(cmp_next), .loop_lat(loop_lat), .victim_sel(victim_sel),
    .lane_mask(lane_mask), .clr_fail(clr_fail), .rx_data(rx_data),
    .tx_data(tx_data), .lane_fail(lane_fail), .any_fail(any_fail),
    .first_lane(first_lane)
  );

  // pad + strobe + capture loop modelled as a chain of bd flops
  always_ff @(posedge clk) begin
    pad[1] <= tx_data;
    for (int i = 2; i <= 4; i++) pad[i] <= pad[i-1];
  end

  always_comb begin
    case (bd)
      0:       rx_data = tx_data ^ inj;
      1:       rx_data = pad[1] ^ inj;
      2:       rx_data = pad[2] ^ inj;
      3:       rx_data = pad[3] ^ inj;
      default: rx_data = pad[4] ^ inj;
    endcase
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_word(input int mode, input int k,
                                            input logic [7:0] msk, input int vic);
    logic [7:0] w;
    for (int i = 0; i < LANES; i++) begin
      logic [6:0] s;
      case (mode)
        0: w[i] = (k % LANES) == i;
        1: w[i] = (k % 2) == 0;
        2: begin
          s = 7'(i + 1);
          for (int j = 0; j < k; j++) s = {s[5:0], s[6] ^ s[5]};
          w[i] = s[6];
        end
        default: w[i] = ((k % 2) == 0) && (i != vic);
      endcase
    end
    return w & msk;
  endfunction

  task automatic idle_clear();
    lb_en = 1'b0;
    inj = 8'h00;
    repeat (7) @(negedge clk);
    clr_fail = 1'b1;
    @(negedge clk);
    clr_fail = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tx_data == 8'h00, "R1 tx", 32'(tx_data), 0);
    check(lane_fail == 8'h00, "R1 lane_fail", 32'(lane_fail), 0);
    check(any_fail == 1'b0, "R1 any_fail", 32'(any_fail), 0);
    check(first_lane == 3'd0, "R1 first_lane", 32'(first_lane), 0);
  endtask

  task automatic t_pattern(input int mode, input logic [7:0] msk, input int vic,
                           input string tag);
    idle_clear();
    pat_mode = 2'(mode); lane_mask = msk; victim_sel = 3'(vic);
    cmp_next = 1'b0; loop_lat = 2'd0; bd = 1;
    check(tx_data == 8'h00, "R2 idle tx", 32'(tx_data), 0);
    lb_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(tx_data == model_word(mode, k, msk, vic), tag, 32'(tx_data),
            32'(model_word(mode, k, msk, vic)));
    end
    check(lane_fail == 8'h00, "R8 aligned no fail", 32'(lane_fail), 0);
  endtask

  task automatic t_latency(input int lat, input int dly, input bit nxt,
                           input bit expect_fail, input string tag);
    idle_clear();
    pat_mode = 2'b01; lane_mask = 8'hFF; cmp_next = nxt;
    loop_lat = 2'(lat); bd = dly;
    lb_en = 1'b1;
    repeat (15) @(negedge clk);
    check(any_fail == expect_fail, tag, 32'(any_fail), 32'(expect_fail));
    cmp_next = 1'b0;
  endtask

  task automatic t_inject();
    idle_clear();
    pat_mode = 2'b01; lane_mask = 8'hFF; loop_lat = 2'd2; bd = 3;
    lb_en = 1'b1;
    repeat (10) @(negedge clk);
    check(any_fail == 1'b0, "R10 clean before flip", 32'(any_fail), 0);
    inj = 8'h24;
    @(negedge clk);
    inj = 8'h00;
    check(lane_fail == 8'h24, "R10 lanes set", 32'(lane_fail), 32'h24);
    check(any_fail == 1'b1, "R10 any set", 32'(any_fail), 1);
    check(first_lane == 3'd2, "R11 lowest lane", 32'(first_lane), 2);
    repeat (3) @(negedge clk);
    inj = 8'h02;
    @(negedge clk);
    inj = 8'h00;
    check(lane_fail == 8'h26, "R10 accumulate", 32'(lane_fail), 32'h26);
    check(first_lane == 3'd2, "R11 first held", 32'(first_lane), 2);
    repeat (5) @(negedge clk);
    check(lane_fail == 8'h26, "R10 sticky", 32'(lane_fail), 32'h26);
    // clear and a fresh flip on the same edge
    inj = 8'h40; clr_fail = 1'b1;
    @(negedge clk);
    inj = 8'h00; clr_fail = 1'b0;
    check(lane_fail == 8'h40, "R12 only new lane", 32'(lane_fail), 32'h40);
    check(first_lane == 3'd6, "R12 new first", 32'(first_lane), 6);
    clr_fail = 1'b1;
    @(negedge clk);
    clr_fail = 1'b0;
    check(lane_fail == 8'h00, "R10 cleared", 32'(lane_fail), 0);
    check(any_fail == 1'b0, "R10 any cleared", 32'(any_fail), 0);
  endtask

  task automatic t_mask_ignore();
    idle_clear();
    pat_mode = 2'b01; lane_mask = 8'h0F; loop_lat = 2'd0; bd = 1;
    lb_en = 1'b1;
    repeat (6) @(negedge clk);
    inj = 8'hF0;
    @(negedge clk);
    inj = 8'h00;
    @(negedge clk);
    check(lane_fail == 8'h00, "R7 masked flip ignored", 32'(lane_fail), 0);
    check((tx_data & 8'hF0) == 8'h00, "R7 masked lanes low", 32'(tx_data), 0);
    lane_mask = 8'hFF;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_pattern(0, 8'hFF, 0, "R3 walking one");
    t_pattern(1, 8'hFF, 0, "R4 all toggle");
    t_pattern(2, 8'hFF, 0, "R5 per-lane prbs");
    t_pattern(3, 8'hFF, 5, "R6 victim quiet");
    t_pattern(0, 8'hF0, 0, "R7 masked walk");
    t_pattern(2, 8'h5A, 0, "R2 restart after idle");
    t_latency(0, 1, 1'b0, 1'b0, "R8 lat1 aligned");
    t_latency(3, 4, 1'b0, 1'b0, "R8 lat4 aligned");
    t_latency(3, 3, 1'b0, 1'b1, "R8 lat4 short fails");
    t_latency(1, 1, 1'b1, 1'b0, "R9 next aligned");
    t_latency(1, 2, 1'b1, 1'b1, "R9 next late fails");
    t_latency(0, 0, 1'b1, 1'b0, "R9 next lat1 direct");
    t_inject();
    t_mask_ignore();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule